// File: doc/BRIEF.md
# Atomic Read-Modify-Write Engine

This block sits between a processor core and a single-port synchronous memory and carries out one indivisible memory update per request. A request names an operation, a width (full 64-bit word or narrow 32-bit word), a byte address, a 64-bit operand and a destination register index. The engine reads the addressed word and decides whether and what to write back. It then returns the word it read, so the core always learns the value that was in memory before the update.

Six update kinds are provided: unconditional swap, conditional swap against a local compare register, add, add that only commits a non-negative sum, bitwise AND and bitwise OR. Narrow requests sign-extend the 32-bit word before any comparison or return. From acceptance until the response cycle the engine reports busy and refuses further requests, so no other access can fall between its read and its write. Alignment errors, memory access errors and results aimed at registers that cannot be written are reported as faults on the response.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Every accepted, aligned request first issues a memory read at its address, and the response carries the word read in `rsp_data` (sign-extended from `mem_rdata[31:0]` for narrow requests), with `rsp_wr`=1 and `rsp_fault`=0 when the destination is an ordinary register. Opcodes: 0 swap, 1 conditional swap, 2 add, 3 add-if-non-negative, 4 AND, 5 OR.
- R2: Conditional swap (opcode 1) writes the operand only when the read value equals the compare register; a narrow request compares the sign-extended 32-bit word against the sign-extended low 32 bits of the compare register. On a mismatch no write is issued.
- R3: Swap (opcode 0) always writes the operand, whatever the compare register holds.
- R4: Add (2), AND (4) and OR (5) always write the old value plus, AND-ed with, or OR-ed with the operand.
- R5: Add-if-non-negative (3) writes the sum only when its sign bit is clear: bit 63 for full requests, bit 31 for narrow ones; otherwise no write is issued.
- R6: Narrow requests need 4-byte alignment, drive `mem_narrow`=1 on both accesses, and the value written is `mem_wdata[31:0]`.
- R7: A full request whose address bits [2:0] are not zero, or a narrow one whose bits [1:0] are not zero, gets `rsp_fault`=1 with `rsp_fault_addr` set to the address and causes no memory access.
- R8: If the memory returns `mem_err` with the read or the write acknowledge, the sequence stops at once, `rsp_fault`=2, `rsp_fault_addr` is the request address and `rsp_wr`=0.
- R9: Destination 63 (constant zero) and 62 (sink) give `rsp_wr`=0 with no fault; destinations 56 to 61 (network-mapped) give `rsp_fault`=3 and `rsp_wr`=0 after the memory update has completed; destinations 0 to 55 are written.
- R10: The compare register is loaded only through `cmpv_we`/`cmpv_wdata`; no atomic request alters it.
- R11: `busy` is 0 after reset, rises in the cycle after acceptance and stays 1 through the single-cycle `rsp_valid`; a request presented while busy is ignored and produces neither an access nor a response.
- R12: Opcodes 6 and 7 read and return the old value but never write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `busy` is 0 |
| req_op | input | 3 | Operation code |
| req_narrow | input | 1 | 1 = 32-bit form, 0 = 64-bit form |
| req_addr | input | ADDR_W | Byte address |
| req_operand | input | DATA_W | Operand value |
| req_dest | input | 6 | Destination register index |
| busy | output | 1 | Sequence in progress |
| cmpv_we | input | 1 | Load the compare register |
| cmpv_wdata | input | DATA_W | New compare register value |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_narrow | output | 1 | Access is 32 bits wide |
| mem_addr | output | ADDR_W | Access byte address |
| mem_wdata | output | DATA_W | Write data (low 32 bits for narrow) |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Access failed, valid with `mem_ack` |
| rsp_valid | output | 1 | Response cycle |
| rsp_wr | output | 1 | Write `rsp_data` to the register file |
| rsp_dest | output | 6 | Destination register index |
| rsp_data | output | DATA_W | Old memory value |
| rsp_fault | output | 2 | 0 none, 1 alignment, 2 access, 3 illegal register |
| rsp_fault_addr | output | ADDR_W | Address of the faulting request |

## Verification
Every opcode, in both widths, is swept over the cross product of six old-memory patterns and six operands chosen around the sign boundaries at bits 31 and 63, so that carries across bit 31, negative sums that only the narrow form sees, and sign-extension of the returned word are each distinguished. Compare values alternate between an exact match and a one-bit mismatch, with junk in the upper half for narrow matches, which separates a full-width compare from a low-half compare and shows that swap ignores the register. Narrow accesses alternate between the lower and upper word of a 64-bit location while the memory model fills unused read bits with garbage. Directed cases then cover misaligned addresses, read and write errors, each destination class and a request pushed in while busy.

// File: rtl/atom_pkg.sv
package atom_pkg;

    localparam int REG_W = 6;
    localparam int GPR_COUNT = 56;
    localparam int SINK_IDX = 62;
    localparam int ZERO_IDX = 63;

    localparam logic [2:0] OPC_SWAP  = 3'd0;
    localparam logic [2:0] OPC_CSWAP = 3'd1;
    localparam logic [2:0] OPC_ADD   = 3'd2;
    localparam logic [2:0] OPC_ADDNN = 3'd3;
    localparam logic [2:0] OPC_AND   = 3'd4;
    localparam logic [2:0] OPC_OR    = 3'd5;

    localparam logic [1:0] FLT_NONE   = 2'd0;
    localparam logic [1:0] FLT_ALIGN  = 2'd1;
    localparam logic [1:0] FLT_ACCESS = 2'd2;
    localparam logic [1:0] FLT_BADREG = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_RESP  = 2'd3
    } state_e;

endpackage

// File: rtl/atom_align_chk.sv
module atom_align_chk #(
    parameter int DATA_W = 64
) (
    input  logic [$clog2(DATA_W/8)-1:0] addr_lo,
    input  logic                        narrow,
    output logic                        misaligned
);
    localparam int FULL_LSB = $clog2(DATA_W/8);
    localparam int HALF_LSB = FULL_LSB - 1;

    logic full_bad;
    logic half_bad;

    assign full_bad = |addr_lo;

    generate
        if (HALF_LSB > 0) begin : g_half_check
            assign half_bad = |addr_lo[HALF_LSB-1:0];
        end else begin : g_half_free
            assign half_bad = 1'b0;
        end
    endgenerate

    assign misaligned = narrow ? half_bad : full_bad;
endmodule

// File: rtl/atom_dest_class.sv
module atom_dest_class
    import atom_pkg::*;
(
    input  logic [REG_W-1:0] dest,
    output logic             to_gpr,
    output logic             illegal
);
    always_comb begin
        to_gpr  = 1'b0;
        illegal = 1'b0;
        if (int'(dest) < GPR_COUNT) begin
            to_gpr = 1'b1;
        end else if (int'(dest) != SINK_IDX && int'(dest) != ZERO_IDX) begin
            illegal = 1'b1;
        end
    end
endmodule

// File: rtl/atom_alu.sv
module atom_alu
    import atom_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [2:0]        op,
    input  logic              narrow,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] cmpv,
    output logic [DATA_W-1:0] new_val,
    output logic              do_write
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] cmp_ref;
    logic [DATA_W-1:0] sum;
    logic              sum_neg;

    assign cmp_ref = narrow ? {{HALF{cmpv[HALF-1]}}, cmpv[HALF-1:0]} : cmpv;
    assign sum     = old_val + operand;
    assign sum_neg = narrow ? sum[HALF-1] : sum[DATA_W-1];

    always_comb begin
        new_val  = old_val;
        do_write = 1'b0;
        case (op)
            OPC_SWAP: begin
                new_val  = operand;
                do_write = 1'b1;
            end
            OPC_CSWAP: begin
                new_val  = operand;
                do_write = (old_val == cmp_ref);
            end
            OPC_ADD: begin
                new_val  = sum;
                do_write = 1'b1;
            end
            OPC_ADDNN: begin
                new_val  = sum;
                do_write = !sum_neg;
            end
            OPC_AND: begin
                new_val  = old_val & operand;
                do_write = 1'b1;
            end
            OPC_OR: begin
                new_val  = old_val | operand;
                do_write = 1'b1;
            end
            default: begin
                new_val  = old_val;
                do_write = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import atom_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic              req_narrow,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_operand,
    input  logic [REG_W-1:0]  req_dest,
    output logic              busy,
    input  logic              cmpv_we,
    input  logic [DATA_W-1:0] cmpv_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_narrow,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              rsp_valid,
    output logic              rsp_wr,
    output logic [REG_W-1:0]  rsp_dest,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_fault,
    output logic [ADDR_W-1:0] rsp_fault_addr
);
    localparam int HALF     = DATA_W / 2;
    localparam int FULL_LSB = $clog2(DATA_W/8);

    typedef struct packed {
        state_e            st;
        logic [2:0]        op;
        logic              narrow;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] operand;
        logic [REG_W-1:0]  dest;
        logic [DATA_W-1:0] old;
        logic [DATA_W-1:0] newv;
        logic [1:0]        fault;
        logic [DATA_W-1:0] cmpv;
    } regs_t;

    regs_t q, d;

    logic              req_misaligned;
    logic              dest_gpr;
    logic              dest_illegal;
    logic [DATA_W-1:0] rd_ext;
    logic [DATA_W-1:0] alu_new;
    logic              alu_wr;

    atom_align_chk #(.DATA_W(DATA_W)) u_align (
        .addr_lo    (req_addr[FULL_LSB-1:0]),
        .narrow     (req_narrow),
        .misaligned (req_misaligned)
    );

    atom_dest_class u_dest (
        .dest    (q.dest),
        .to_gpr  (dest_gpr),
        .illegal (dest_illegal)
    );

    assign rd_ext = q.narrow ? {{HALF{mem_rdata[HALF-1]}}, mem_rdata[HALF-1:0]}
                             : mem_rdata;

    atom_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (q.op),
        .narrow   (q.narrow),
        .old_val  (rd_ext),
        .operand  (q.operand),
        .cmpv     (q.cmpv),
        .new_val  (alu_new),
        .do_write (alu_wr)
    );

    always_comb begin
        d = q;
        if (cmpv_we) begin
            d.cmpv = cmpv_wdata;
        end
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.op      = req_op;
                    d.narrow  = req_narrow;
                    d.addr    = req_addr;
                    d.operand = req_operand;
                    d.dest    = req_dest;
                    d.old     = '0;
                    d.newv    = '0;
                    if (req_misaligned) begin
                        d.fault = FLT_ALIGN;
                        d.st    = ST_RESP;
                    end else begin
                        d.fault = FLT_NONE;
                        d.st    = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        d.fault = FLT_ACCESS;
                        d.st    = ST_RESP;
                    end else begin
                        d.old  = rd_ext;
                        d.newv = alu_new;
                        if (alu_wr) begin
                            d.st = ST_WRITE;
                        end else begin
                            d.st = ST_RESP;
                            if (dest_illegal) begin
                                d.fault = FLT_BADREG;
                            end
                        end
                    end
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    d.st = ST_RESP;
                    if (mem_err) begin
                        d.fault = FLT_ACCESS;
                    end else if (dest_illegal) begin
                        d.fault = FLT_BADREG;
                    end
                end
            end
            ST_RESP: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy           = (q.st != ST_IDLE);
    assign mem_req        = (q.st == ST_READ) || (q.st == ST_WRITE);
    assign mem_we         = (q.st == ST_WRITE);
    assign mem_narrow     = q.narrow;
    assign mem_addr       = q.addr;
    assign mem_wdata      = q.newv;
    assign rsp_valid      = (q.st == ST_RESP);
    assign rsp_wr         = rsp_valid && (q.fault == FLT_NONE) && dest_gpr;
    assign rsp_dest       = q.dest;
    assign rsp_data       = q.old;
    assign rsp_fault      = q.fault;
    assign rsp_fault_addr = q.addr;

    // A write access only ever follows a clean read acknowledge.
    assert_write_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_ack && !mem_err));

    // No access may be made to a misaligned address.
    assert_aligned_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (q.narrow ? (q.addr[1:0] == 2'b00) : (q.addr[2:0] == 3'b000)));

    // Register file writes only target ordinary registers.
    assert_dest_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr |-> (int'(rsp_dest) < GPR_COUNT));

    // The response is delivered while the engine still reports busy.
    assert_rsp_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);

    // The address held for the sequence cannot be disturbed while busy.
    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mem_addr));

    // Compare register changes only through its own write port.
    assert_cmpv_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmpv_we) |-> $stable(q.cmpv));

endmodule

// File: tb/sim_atomic_rmw_unit.sv
module sim_atomic_rmw_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic        req_narrow = 1'b0;
    logic [15:0] req_addr = '0;
    logic [63:0] req_operand = '0;
    logic [5:0]  req_dest = '0;
    logic        busy;
    logic        cmpv_we = 1'b0;
    logic [63:0] cmpv_wdata = '0;
    logic        mem_req, mem_we, mem_narrow;
    logic [15:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        rsp_valid, rsp_wr;
    logic [5:0]  rsp_dest;
    logic [63:0] rsp_data;
    logic [1:0]  rsp_fault;
    logic [15:0] rsp_fault_addr;

    always #10 clk = ~clk;

    atomic_rmw_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_narrow(req_narrow),
        .req_addr(req_addr), .req_operand(req_operand), .req_dest(req_dest),
        .busy(busy), .cmpv_we(cmpv_we), .cmpv_wdata(cmpv_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_narrow(mem_narrow),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_err(mem_err),
        .rsp_valid(rsp_valid), .rsp_wr(rsp_wr), .rsp_dest(rsp_dest),
        .rsp_data(rsp_data), .rsp_fault(rsp_fault), .rsp_fault_addr(rsp_fault_addr)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Memory model: 32 words of 64 bits; 0x80-0xBF rejects writes, 0xC0-0xFF rejects everything.
    logic [63:0] mem [32];
    int acc_cnt = 0;
    int wr_cnt = 0;

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (mem_req) begin
            logic [4:0] idx;
            logic       bad;
            idx = mem_addr[7:3];
            bad = (mem_addr[7:6] == 2'b11) || (mem_we && mem_addr[7:6] == 2'b10);
            acc_cnt++;
            if (mem_we) begin
                wr_cnt++;
                if (!bad) begin
                    if (mem_narrow) begin
                        if (mem_addr[2]) mem[idx][63:32] = mem_wdata[31:0];
                        else             mem[idx][31:0]  = mem_wdata[31:0];
                    end else begin
                        mem[idx] = mem_wdata;
                    end
                end
            end else begin
                if (mem_narrow)
                    mem_rdata = {32'hA5A5_0F0F, (mem_addr[2] ? mem[idx][63:32] : mem[idx][31:0])};
                else
                    mem_rdata = mem[idx];
            end
            mem_err = bad;
            mem_ack = 1'b1;
        end
    end

    // Response monitor
    int          rsp_cnt = 0;
    logic        c_wr;
    logic [63:0] c_data;
    logic [1:0]  c_fault;
    logic [15:0] c_faddr;
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            rsp_cnt++;
            c_wr    = rsp_wr;
            c_data  = rsp_data;
            c_fault = rsp_fault;
            c_faddr = rsp_fault_addr;
        end
    end

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, act=%0d cycles exp<=150000", cycles);
            summary_and_end();
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic set_cmpv(input logic [63:0] v);
        @(negedge clk);
        cmpv_we = 1'b1;
        cmpv_wdata = v;
        @(negedge clk);
        cmpv_we = 1'b0;
    endtask

    int acc0, wr0, rsp0;
    logic busy_after_accept;

    task automatic run_op(input logic [2:0] op, input logic nar, input logic [7:0] a,
                          input logic [63:0] opnd, input logic [5:0] dst, input bit poke);
        @(negedge clk);
        while (busy) @(negedge clk);
        acc0 = acc_cnt;
        wr0  = wr_cnt;
        rsp0 = rsp_cnt;
        req_valid   = 1'b1;
        req_op      = op;
        req_narrow  = nar;
        req_addr    = {8'h00, a};
        req_operand = opnd;
        req_dest    = dst;
        @(negedge clk);
        req_valid = 1'b0;
        busy_after_accept = busy;
        if (poke) begin
            req_valid   = 1'b1;
            req_op      = 3'd0;
            req_narrow  = 1'b0;
            req_addr    = 16'h0040;
            req_operand = 64'h7777_7777_7777_7777;
            req_dest    = 6'd1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (rsp_cnt == rsp0) @(negedge clk);
    endtask

    // Independent expectation from the requirements
    task automatic model(input logic [2:0] op, input logic nar, input logic [7:0] a,
                         input logic [63:0] word, input logic [63:0] opnd, input logic [63:0] cv,
                         output logic [63:0] old, output logic wr, output logic [63:0] after);
        logic [31:0] part;
        logic [63:0] nv;
        logic [63:0] s;
        logic        eq;
        part = a[2] ? word[63:32] : word[31:0];
        old  = nar ? {{32{part[31]}}, part} : word;
        eq   = nar ? (part == cv[31:0]) : (word == cv);
        s    = old + opnd;
        nv   = old;
        wr   = 1'b0;
        case (op)
            3'd0: begin nv = opnd;       wr = 1'b1; end
            3'd1: begin nv = opnd;       wr = eq; end
            3'd2: begin nv = s;          wr = 1'b1; end
            3'd3: begin nv = s;          wr = nar ? !s[31] : !s[63]; end
            3'd4: begin nv = old & opnd; wr = 1'b1; end
            3'd5: begin nv = old | opnd; wr = 1'b1; end
            default: begin nv = old;     wr = 1'b0; end
        endcase
        after = word;
        if (wr) begin
            if (nar) begin
                if (a[2]) after[63:32] = nv[31:0];
                else      after[31:0]  = nv[31:0];
            end else begin
                after = nv;
            end
        end
    endtask

    logic [63:0] pats [6];
    logic [63:0] opnds [6];

    initial begin
        logic [63:0] old_e, after_e, cv;
        logic        wr_e;
        logic [7:0]  a;
        logic [63:0] saved;
        string       tag;

        pats[0]  = 64'h0000_0000_0000_0000;
        pats[1]  = 64'h0000_0000_7FFF_FFFF;
        pats[2]  = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[3]  = 64'h7FFF_FFFF_8000_0000;
        pats[4]  = 64'h8000_0000_0000_0005;
        pats[5]  = 64'h1234_5678_9ABC_DEF0;
        opnds[0] = 64'h0000_0000_0000_0001;
        opnds[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        opnds[2] = 64'h0000_0000_8000_0000;
        opnds[3] = 64'h8000_0000_0000_0000;
        opnds[4] = 64'h0F0F_0F0F_F0F0_F0F0;
        opnds[5] = 64'hFFFF_FFFF_FFFF_FFF0;
        for (int k = 0; k < 32; k++) mem[k] = 64'h1111_0000_0000_0000 + 64'(k);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset busy", {63'd0, busy}, 64'd0);
        chk("R11 reset mem_req", {63'd0, mem_req}, 64'd0);
        chk("R11 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);

        // Sweep: every opcode, both widths, old patterns x operands
        for (int op = 0; op < 8; op++) begin
            for (int nar = 0; nar < 2; nar++) begin
                for (int i = 0; i < 6; i++) begin
                    for (int j = 0; j < 6; j++) begin
                        a = (nar == 1) ? ((j % 2 == 1) ? 8'h14 : 8'h10) : 8'h18;
                        mem[a[7:3]] = pats[i] ^ {pats[(i + j) % 6][31:0], pats[(i + j) % 6][63:32]};
                        if (nar == 1) begin
                            saved = a[2] ? {32'd0, mem[a[7:3]][63:32]} : {32'd0, mem[a[7:3]][31:0]};
                            cv = (j % 2 == 0) ? {32'h1357_9BDF, saved[31:0]}
                                              : {32'h0, saved[31:0]} ^ 64'h1;
                        end else begin
                            cv = (j % 2 == 0) ? mem[a[7:3]] : mem[a[7:3]] ^ 64'h1;
                        end
                        set_cmpv(cv);
                        model(3'(op), nar[0], a, mem[a[7:3]], opnds[j], cv, old_e, wr_e, after_e);
                        run_op(3'(op), nar[0], a, opnds[j], 6'd5, 1'b0);
                        case (op)
                            0: tag = "R3 swap";
                            1: tag = "R2 cswap";
                            2: tag = "R4 add";
                            3: tag = "R5 addnn";
                            4: tag = "R4 and";
                            5: tag = "R4 or";
                            default: tag = "R12 reserved";
                        endcase
                        chk("R1 old value", c_data, old_e);
                        chk("R1 wr/fault", {61'd0, c_wr, c_fault}, {61'd0, 1'b1, 2'd0});
                        chk({tag, (nar == 1) ? " R6 narrow mem" : " mem"}, mem[a[7:3]], after_e);
                        chk({tag, " accesses"}, 64'(acc_cnt - acc0), wr_e ? 64'd2 : 64'd1);
                        chk("R11 busy after accept", {63'd0, busy_after_accept}, 64'd1);
                    end
                end
            end
        end

        // R7 misaligned full and narrow
        run_op(3'd0, 1'b0, 8'h0C, 64'h1, 6'd3, 1'b0);
        chk("R7 full misaligned fault", {62'd0, c_fault}, 64'd1);
        chk("R7 full misaligned addr", {48'd0, c_faddr}, 64'h000C);
        chk("R7 full misaligned accesses", 64'(acc_cnt - acc0), 64'd0);
        run_op(3'd2, 1'b1, 8'h06, 64'h1, 6'd3, 1'b0);
        chk("R7 narrow misaligned fault", {62'd0, c_fault}, 64'd1);
        chk("R7 narrow misaligned accesses", 64'(acc_cnt - acc0), 64'd0);
        chk("R7 no register write", {63'd0, c_wr}, 64'd0);

        // R8 read error and write error
        run_op(3'd0, 1'b0, 8'hC8, 64'h5, 6'd3, 1'b0);
        chk("R8 read error fault", {62'd0, c_fault}, 64'd2);
        chk("R8 read error addr", {48'd0, c_faddr}, 64'h00C8);
        chk("R8 read error accesses", 64'(acc_cnt - acc0), 64'd1);
        chk("R8 read error no wr", {63'd0, c_wr}, 64'd0);
        saved = mem[5'h11];
        run_op(3'd0, 1'b0, 8'h88, 64'h5, 6'd3, 1'b0);
        chk("R8 write error fault", {62'd0, c_fault}, 64'd2);
        chk("R8 write error accesses", 64'(acc_cnt - acc0), 64'd2);
        chk("R8 write error memory", mem[5'h11], saved);
        chk("R8 write error no wr", {63'd0, c_wr}, 64'd0);

        // R9 destination classes
        mem[4] = 64'h10;
        run_op(3'd2, 1'b0, 8'h20, 64'h1, 6'd63, 1'b0);
        chk("R9 zero reg no wr", {61'd0, c_wr, c_fault}, 64'd0);
        chk("R9 zero reg mem updated", mem[4], 64'h11);
        run_op(3'd2, 1'b0, 8'h20, 64'h1, 6'd62, 1'b0);
        chk("R9 sink reg no wr", {61'd0, c_wr, c_fault}, 64'd0);
        chk("R9 sink reg mem updated", mem[4], 64'h12);
        run_op(3'd2, 1'b0, 8'h20, 64'h1, 6'd58, 1'b0);
        chk("R9 network reg fault", {61'd0, c_wr, c_fault}, {61'd0, 1'b0, 2'd3});
        chk("R9 network reg mem updated", mem[4], 64'h13);
        run_op(3'd12 == 3'd0 ? 3'd0 : 3'd6, 1'b0, 8'h20, 64'h1, 6'd56, 1'b0);
        chk("R9 network reg fault no write", {61'd0, c_wr, c_fault}, {61'd0, 1'b0, 2'd3});
        run_op(3'd2, 1'b0, 8'h20, 64'h1, 6'd55, 1'b0);
        chk("R9 last gpr written", {61'd0, c_wr, c_fault}, {61'd0, 1'b1, 2'd0});
        chk("R9 last gpr data", c_data, 64'h13);

        // R10 compare register survives other operations
        set_cmpv(64'hCAFE_0000_0000_BEEF);
        mem[6] = 64'h5;
        run_op(3'd0, 1'b0, 8'h30, 64'h9, 6'd2, 1'b0);
        run_op(3'd2, 1'b0, 8'h30, 64'h9, 6'd2, 1'b0);
        mem[6] = 64'hCAFE_0000_0000_BEEF;
        run_op(3'd1, 1'b0, 8'h30, 64'h42, 6'd2, 1'b0);
        chk("R10 compare value kept", mem[6], 64'h42);

        // R11 request while busy is ignored
        mem[8] = 64'hAAAA;
        mem[7] = 64'h3;
        run_op(3'd2, 1'b0, 8'h38, 64'h4, 6'd2, 1'b1);
        repeat (6) @(negedge clk);
        chk("R11 refused request no access", mem[8], 64'hAAAA);
        chk("R11 single response", 64'(rsp_cnt - rsp0), 64'd1);
        chk("R11 accepted op done", mem[7], 64'h7);
        chk("R11 idle afterwards", {63'd0, busy}, 64'd0);

        summary_and_end();
    end

endmodule